// File: doc/BRIEF.md
# USB Low/Full-Speed Packet Line Transmitter

This block turns a packet request into the bit-level signalling on a USB line pair at low or full speed. A request supplies a 4-bit packet identifier, an optional payload delivered byte by byte through a valid/ready handshake with a last flag, a speed select, and a flag that asks for a CRC16 to be appended. The block sends the synchronisation pattern, then the identifier byte with its check nibble, then the payload and the optional CRC. Every byte goes out least significant bit first. The bit stream is then bit-stuffed and NRZI-encoded, and the frame closes with an end-of-packet sequence.

Two other requests produce line signalling with no packet bits. One is a bus reset, a long single-ended zero followed by release. The other is a low-speed keep-alive, an end-of-packet pattern on its own. The transmitter stays off the line while the receive side reports activity, and it reports when it owns the line.

The line outputs are a drive enable, a single-ended-zero strobe and the D+ level. All three change only on bit boundaries, which come from a clock divider. The divider gives `FS_CLKS` cycles per bit at full speed and `FS_CLKS*LS_MULT` cycles per bit at low speed.

Top module: `usb_ls_fs_tx`

## Requirements
- R1: After reset, tx_en, tx_se0, tx_dat, busy and byte_ready are all low.
- R2: A packet request (cmd 0) sends byte 0x80, then the identifier byte with pid in bits 3:0 and ~pid in bits 7:4, then the payload and the optional CRC. Each byte goes out bit 0 first.
- R3: After six consecutive one bits, a zero bit is inserted if another data bit follows. No bit is inserted when the end-of-packet follows.
- R4: NRZI starts from the J level. A 0 bit toggles the level and a 1 bit holds it. tx_dat is the D+ level: J is tx_dat=1 at full speed (low_speed=0) and tx_dat=0 at low speed (low_speed=1). K is the opposite level.
- R5: A packet ends with tx_se0 high for two bit times, then J for one bit time. tx_en then drops.
- R6: A bit time is FS_CLKS cycles at full speed and FS_CLKS*LS_MULT cycles at low speed. The first symbol is driven one bit time after the request is accepted. The line outputs change only at bit boundaries.
- R7: A payload byte is transferred in a cycle where byte_ready and byte_valid are both high. The byte carrying byte_last is the final payload byte. byte_ready is high only while the line is driven.
- R8: With add_crc set, the USB CRC16 of the payload (polynomial 0x8005, all-ones start, result reflected and inverted) follows the payload, low byte first. With no payload it is 0x00 0x00.
- R9: If byte_valid is low when byte_ready is high, no byte is taken. The end-of-packet follows the current byte at once, and no CRC is sent.
- R10: cmd 1 (keep-alive) drives SE0, SE0, J at the selected bit time, then releases the line.
- R11: cmd 2 or 3 (bus reset) drives SE0 for RESET_BITS full-speed bit times whatever the speed select, then releases the line with no J.
- R12: start is ignored while busy or rx_busy is high. busy rises the cycle after a request is accepted and falls on the same edge as tx_en.
- R13: tx_se0 is high only while tx_en is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe |
| cmd | input | 2 | 0 packet, 1 keep-alive, 2/3 bus reset |
| pid | input | 4 | Packet identifier |
| low_speed | input | 1 | 1 selects low-speed bit time and polarity |
| with_payload | input | 1 | Packet carries payload bytes |
| add_crc | input | 1 | Append CRC16 after payload |
| rx_busy | input | 1 | Receive path active; blocks new requests |
| byte_data | input | 8 | Payload byte |
| byte_valid | input | 1 | Payload byte present |
| byte_last | input | 1 | Payload byte is the final one |
| byte_ready | output | 1 | Payload byte taken this cycle if valid |
| busy | output | 1 | Transmitter owns the line |
| tx_en | output | 1 | Line drive enable |
| tx_se0 | output | 1 | Drive single-ended zero |
| tx_dat | output | 1 | D+ level when not SE0 |

## Verification
The bench goes after runs of ones that straddle byte boundaries and runs of six ones that end just before the end-of-packet. A design that stuffs by byte, or stuffs before SE0, shifts every later symbol. A zero-length packet with CRC must yield 0x0000; a design that skips the CRC phase with no payload ends two bytes early. A payload underrun must close the frame without CRC bits. Low-speed packets check the inverted J polarity and the eightfold bit time. A bus reset sent with low speed selected must still use full-speed bit times and must not add a trailing J.

// File: rtl/usb_tx_pkg.sv
package usb_tx_pkg;

  typedef enum logic [3:0] {
    PH_IDLE, PH_SYNC, PH_PID, PH_DATA, PH_CRC,
    PH_EOP_SE0, PH_EOP_J, PH_RST, PH_DONE
  } phase_t;

  typedef enum logic [1:0] {SYM_OFF, SYM_SE0, SYM_J, SYM_BIT} sym_t;

  localparam logic [7:0]  SYNC_PATTERN = 8'h80;
  localparam logic [15:0] CRC16_POLY   = 16'h8005;
  localparam logic [15:0] CRC16_SEED   = 16'hFFFF;
  localparam logic [2:0]  STUFF_RUN    = 3'd6;

  // identifier byte: value low, its complement high
  function automatic logic [7:0] pid_byte(input logic [3:0] p);
    return {~p, p};
  endfunction

  // one serial CRC16 step, MSB-first register, data bit in wire order
  function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic b);
    logic fb;
    fb = b ^ c[15];
    return {c[14:0], 1'b0} ^ (fb ? CRC16_POLY : 16'h0000);
  endfunction

endpackage

// File: rtl/usb_tx_bitclk.sv
module usb_tx_bitclk #(
  parameter int FS_CLKS = 4,
  parameter int LS_MULT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic low_speed,
  output logic tick
);
  localparam int LS_CLKS = FS_CLKS * LS_MULT;
  localparam int CW      = (LS_CLKS > 1) ? $clog2(LS_CLKS) : 1;
  localparam logic [CW-1:0] FS_LAST = CW'(FS_CLKS - 1);
  localparam logic [CW-1:0] LS_LAST = CW'(LS_CLKS - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;

  assign last = low_speed ? LS_LAST : FS_LAST;
  assign tick = (cnt == last);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) cnt <= '0;
    else if (tick)         cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/usb_tx_crc16.sv
module usb_tx_crc16 import usb_tx_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic update,
  input  logic data_bit,
  input  logic shift,
  output logic crc_bit
);
  logic [15:0] crc_q;

  // reflected-and-inverted output, taken MSB first from the register
  assign crc_bit = ~crc_q[15];

  always_ff @(posedge clk) begin
    if (!rst_n || clear) crc_q <= CRC16_SEED;
    else if (update)     crc_q <= crc16_step(crc_q, data_bit);
    else if (shift)      crc_q <= {crc_q[14:0], 1'b1};
  end
endmodule

// File: rtl/usb_tx_line.sv
module usb_tx_line import usb_tx_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic start,
  input  logic low_speed,
  input  sym_t sym,
  input  logic bit_in,
  output logic stuff_now,
  output logic tx_en,
  output logic tx_se0,
  output logic tx_dat
);
  logic       lvl_j;
  logic [2:0] ones;
  logic       en_q, se0_q;

  assign stuff_now = (sym == SYM_BIT) && (ones == STUFF_RUN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      se0_q <= 1'b0;
      lvl_j <= 1'b1;
      ones  <= '0;
    end else if (start) begin
      lvl_j <= 1'b1;
      ones  <= '0;
    end else if (tick) begin
      case (sym)
        SYM_OFF: begin
          en_q  <= 1'b0;
          se0_q <= 1'b0;
          lvl_j <= 1'b1;
          ones  <= '0;
        end
        SYM_SE0: begin
          en_q  <= 1'b1;
          se0_q <= 1'b1;
          ones  <= '0;
        end
        SYM_J: begin
          en_q  <= 1'b1;
          se0_q <= 1'b0;
          lvl_j <= 1'b1;
          ones  <= '0;
        end
        default: begin
          en_q  <= 1'b1;
          se0_q <= 1'b0;
          if (stuff_now || !bit_in) begin
            lvl_j <= ~lvl_j;
            ones  <= '0;
          end else begin
            ones  <= ones + 1'b1;
          end
        end
      endcase
    end
  end

  assign tx_en  = en_q;
  assign tx_se0 = se0_q;
  assign tx_dat = en_q && !se0_q && (lvl_j ^ low_speed);
endmodule

// File: rtl/usb_ls_fs_tx.sv
module usb_ls_fs_tx import usb_tx_pkg::*; #(
  parameter int FS_CLKS    = 4,
  parameter int LS_MULT    = 8,
  parameter int RESET_BITS = 1200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] cmd,
  input  logic [3:0] pid,
  input  logic       low_speed,
  input  logic       with_payload,
  input  logic       add_crc,
  input  logic       rx_busy,
  input  logic [7:0] byte_data,
  input  logic       byte_valid,
  input  logic       byte_last,
  output logic       byte_ready,
  output logic       busy,
  output logic       tx_en,
  output logic       tx_se0,
  output logic       tx_dat
);
  localparam int RCW = $clog2(RESET_BITS + 1);
  localparam logic [RCW-1:0] RST_LAST = RCW'(RESET_BITS - 1);

  phase_t         phase;
  logic [3:0]     idx;
  logic [7:0]     sh;
  logic [3:0]     pid_q;
  logic           ls_q, crc_q, pay_q, last_q;
  logic [RCW-1:0] rst_cnt;

  logic bit_tick, stuff_now, crc_bit;
  logic start_ok, advance, byte_end, need_byte;
  sym_t sym;
  logic sym_bit;

  assign start_ok  = start && (phase == PH_IDLE) && !rx_busy;
  assign advance   = bit_tick && !stuff_now;
  assign byte_end  = (idx[2:0] == 3'd7);
  assign need_byte = advance && byte_end &&
                     (((phase == PH_PID) && pay_q) || ((phase == PH_DATA) && !last_q));
  assign byte_ready = need_byte;
  assign busy       = (phase != PH_IDLE);

  always_comb begin
    sym     = SYM_OFF;
    sym_bit = 1'b0;
    case (phase)
      PH_SYNC, PH_PID, PH_DATA: begin sym = SYM_BIT; sym_bit = sh[0]; end
      PH_CRC:                   begin sym = SYM_BIT; sym_bit = crc_bit; end
      PH_EOP_SE0, PH_RST:       sym = SYM_SE0;
      PH_EOP_J:                 sym = SYM_J;
      default:                  sym = SYM_OFF;
    endcase
  end

  usb_tx_bitclk #(.FS_CLKS(FS_CLKS), .LS_MULT(LS_MULT)) u_bitclk (
    .clk(clk), .rst_n(rst_n), .restart(start_ok), .low_speed(ls_q), .tick(bit_tick)
  );

  usb_tx_crc16 u_crc (
    .clk(clk), .rst_n(rst_n), .clear(start_ok),
    .update(advance && (phase == PH_DATA)), .data_bit(sh[0]),
    .shift(advance && (phase == PH_CRC)), .crc_bit(crc_bit)
  );

  usb_tx_line u_line (
    .clk(clk), .rst_n(rst_n), .tick(bit_tick), .start(start_ok), .low_speed(ls_q),
    .sym(sym), .bit_in(sym_bit), .stuff_now(stuff_now),
    .tx_en(tx_en), .tx_se0(tx_se0), .tx_dat(tx_dat)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      idx     <= '0;
      sh      <= '0;
      pid_q   <= '0;
      ls_q    <= 1'b0;
      crc_q   <= 1'b0;
      pay_q   <= 1'b0;
      last_q  <= 1'b0;
      rst_cnt <= '0;
    end else if (start_ok) begin
      pid_q   <= pid;
      crc_q   <= add_crc;
      pay_q   <= with_payload;
      last_q  <= 1'b0;
      idx     <= '0;
      rst_cnt <= '0;
      sh      <= SYNC_PATTERN;
      ls_q    <= cmd[1] ? 1'b0 : low_speed;
      if (cmd[1])      phase <= PH_RST;
      else if (cmd[0]) phase <= PH_EOP_SE0;
      else             phase <= PH_SYNC;
    end else if (advance) begin
      case (phase)
        PH_SYNC: begin
          sh  <= {1'b0, sh[7:1]};
          idx <= idx + 1'b1;
          if (byte_end) begin
            sh    <= pid_byte(pid_q);
            idx   <= '0;
            phase <= PH_PID;
          end
        end
        PH_PID, PH_DATA: begin
          sh  <= {1'b0, sh[7:1]};
          idx <= idx + 1'b1;
          if (byte_end) begin
            idx <= '0;
            if (need_byte) begin
              if (byte_valid) begin
                sh     <= byte_data;
                last_q <= byte_last;
                phase  <= PH_DATA;
              end else begin
                phase  <= PH_EOP_SE0;
              end
            end else begin
              phase <= crc_q ? PH_CRC : PH_EOP_SE0;
            end
          end
        end
        PH_CRC: begin
          idx <= idx + 1'b1;
          if (idx == 4'd15) begin
            idx   <= '0;
            phase <= PH_EOP_SE0;
          end
        end
        PH_EOP_SE0: begin
          idx <= idx + 1'b1;
          if (idx[0]) begin
            idx   <= '0;
            phase <= PH_EOP_J;
          end
        end
        PH_EOP_J: phase <= PH_DONE;
        PH_RST: begin
          rst_cnt <= rst_cnt + 1'b1;
          if (rst_cnt == RST_LAST) phase <= PH_DONE;
        end
        PH_DONE: phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/usb_ls_fs_tx_chk.sv
module usb_ls_fs_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic busy,
  input logic rx_busy,
  input logic byte_ready,
  input logic tx_en,
  input logic tx_se0,
  input logic tx_dat
);
  logic       new_sym;
  logic       prev_drv, prev_dat;
  logic [3:0] run;

  // track how many consecutive driven bit times hold the same level
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      new_sym  <= 1'b0;
      prev_drv <= 1'b0;
      prev_dat <= 1'b0;
      run      <= '0;
    end else begin
      new_sym <= tick;
      if (new_sym) begin
        if (tx_en && !tx_se0) begin
          if (prev_drv && (tx_dat == prev_dat)) run <= (run == 4'hF) ? run : run + 1'b1;
          else                                 run <= 4'd1;
          prev_drv <= 1'b1;
          prev_dat <= tx_dat;
        end else begin
          prev_drv <= 1'b0;
          run      <= '0;
        end
      end
    end
  end

  a_r13_se0_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    tx_se0 |-> tx_en);

  a_r12_en_within_busy: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en |-> busy);

  a_r12_release_together: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !tx_en);

  a_r12_rx_lockout: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && rx_busy) |=> !busy);

  a_r7_ready_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ready |-> (busy && tx_en));

  a_r6_line_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable({tx_en, tx_se0, tx_dat}));

  a_r3_run_limit: assert property (@(posedge clk) disable iff (!rst_n)
    run <= 4'd7);
endmodule

bind usb_ls_fs_tx usb_ls_fs_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(bit_tick), .busy(busy), .rx_busy(rx_busy),
  .byte_ready(byte_ready), .tx_en(tx_en), .tx_se0(tx_se0), .tx_dat(tx_dat)
);

// File: tb/tb_usb_ls_fs_tx.sv
`timescale 1ns/1ps
module tb_usb_ls_fs_tx;
  localparam int CLK_PERIOD = 10;
  localparam int FS_CLKS    = 4;
  localparam int LS_MULT    = 8;
  localparam int RESET_BITS = 1200;
  localparam int REC_MAX    = 8192;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] cmd = '0;
  logic [3:0] pid = '0;
  logic low_speed = 1'b0, with_payload = 1'b0, add_crc = 1'b0, rx_busy = 1'b0;
  logic [7:0] byte_data = '0;
  logic byte_valid = 1'b0, byte_last = 1'b0;
  logic byte_ready, busy, tx_en, tx_se0, tx_dat;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_ls_fs_tx #(.FS_CLKS(FS_CLKS), .LS_MULT(LS_MULT), .RESET_BITS(RESET_BITS)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .pid(pid), .low_speed(low_speed),
    .with_payload(with_payload), .add_crc(add_crc), .rx_busy(rx_busy),
    .byte_data(byte_data), .byte_valid(byte_valid), .byte_last(byte_last),
    .byte_ready(byte_ready), .busy(busy), .tx_en(tx_en), .tx_se0(tx_se0), .tx_dat(tx_dat)
  );

  int n_tests = 0;
  int n_fail  = 0;

  logic rec_en [0:REC_MAX-1];
  logic rec_se0[0:REC_MAX-1];
  logic rec_dat[0:REC_MAX-1];
  int   rec_n;
  bit   rec_done;
  int   taken;

  logic [7:0] pay_bytes[0:7];
  bit   exp_bits[0:255];
  int   nbits;
  int   exp_sym[0:2047];   // 0 = K, 1 = J, 2 = SE0
  int   exp_n;

  task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic int sym_of(input logic se0, input logic dat, input logic ls);
    if (se0) return 2;
    return (dat == !ls) ? 1 : 0;
  endfunction

  function automatic logic [15:0] usb_crc(input int n);
    logic [15:0] c;
    c = 16'hFFFF;
    for (int i = 0; i < n; i++) begin
      c = c ^ {8'h00, pay_bytes[i]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 16'hA001) : (c >> 1);
    end
    return ~c;
  endfunction

  task automatic exp_clear();
    nbits = 0;
    exp_n = 0;
  endtask

  task automatic exp_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      exp_bits[nbits] = b[i];
      nbits++;
    end
  endtask

  task automatic exp_encode();
    bit lvl;
    int ones;
    lvl = 1'b1;
    ones = 0;
    for (int i = 0; i < nbits; i++) begin
      if (ones == 6) begin
        lvl = !lvl; exp_sym[exp_n] = int'(lvl); exp_n++; ones = 0;
      end
      if (!exp_bits[i]) begin lvl = !lvl; ones = 0; end
      else ones++;
      exp_sym[exp_n] = int'(lvl);
      exp_n++;
    end
    exp_sym[exp_n] = 2; exp_sym[exp_n+1] = 2; exp_sym[exp_n+2] = 1;
    exp_n += 3;
  endtask

  task automatic run_cmd(input logic [1:0] c, input logic [3:0] p, input logic ls, input logic crc,
                         input int n, input int underrun_at, input bit glitch);
    rec_done = 1'b0;
    taken = 0;
    @(negedge clk);
    cmd = c; pid = p; low_speed = ls; add_crc = crc; with_payload = (n > 0); start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    fork
      begin
        rec_n = 0;
        while (1) begin
          @(negedge clk);
          rec_en[rec_n] = tx_en; rec_se0[rec_n] = tx_se0; rec_dat[rec_n] = tx_dat;
          rec_n++;
          if (!busy || rec_n >= REC_MAX) break;
        end
        rec_done = 1'b1;
      end
      begin
        for (int i = 0; i < n; i++) begin
          if (i == underrun_at) break;
          byte_data = pay_bytes[i]; byte_last = (i == n - 1); byte_valid = 1'b1;
          while (1) begin
            @(negedge clk);
            if (rec_done || byte_ready) break;
          end
          if (rec_done) break;
          @(posedge clk); #1;
          byte_valid = 1'b0;
          taken++;
        end
        byte_valid = 1'b0;
      end
      begin
        if (glitch) begin
          repeat (60) @(negedge clk);
          cmd = 2'd1; start = 1'b1;
          @(posedge clk); #1;
          start = 1'b0;
        end
      end
    join
  endtask

  task automatic check_frame(input int per, input logic ls, input string req);
    int first, bad, bad_got, bad_exp, ix, got;
    first = -1; bad = -1; bad_got = 0; bad_exp = 0;
    for (int i = 0; i < rec_n; i++) if (rec_en[i] && first < 0) first = i;
    check(first == per, "R6", "cycles to first symbol", first, per);
    if (first < 0) first = 0;
    for (int k = 0; k < exp_n; k++) begin
      for (int j = 0; j < per; j++) begin
        ix = first + k * per + j;
        got = (ix < rec_n && rec_en[ix]) ? sym_of(rec_se0[ix], rec_dat[ix], ls) : 3;
        if (got != exp_sym[k] && bad < 0) begin bad = k; bad_got = got; bad_exp = exp_sym[k]; end
      end
    end
    check(bad < 0, req, $sformatf("line symbol %0d", bad), bad_got, bad_exp);
    check(rec_n - 1 == first + exp_n * per, "R12", "busy end cycle", rec_n - 1, first + exp_n * per);
    check(!rec_en[rec_n-1] && !rec_se0[rec_n-1], "R5", "line released at end",
          int'(rec_en[rec_n-1]), 0);
  endtask

  task automatic do_packet(input logic [3:0] p, input logic ls, input logic crc, input int n,
                           input int underrun_at, input bit glitch, input string req);
    int acc;
    logic [15:0] cv;
    run_cmd(2'd0, p, ls, crc, n, underrun_at, glitch);
    acc = (underrun_at < 0) ? n : underrun_at;
    check(taken == acc, "R7", "payload bytes taken", taken, acc);
    exp_clear();
    exp_byte(8'h80);
    exp_byte({~p, p});
    for (int i = 0; i < acc; i++) exp_byte(pay_bytes[i]);
    if (crc && underrun_at < 0) begin
      cv = usb_crc(n);
      exp_byte(cv[7:0]);
      exp_byte(cv[15:8]);
    end
    exp_encode();
    check_frame(ls ? FS_CLKS * LS_MULT : FS_CLKS, ls, req);
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    check({tx_en, tx_se0, tx_dat, busy, byte_ready} == 5'b0, "R1", "outputs after reset",
          int'({tx_en, tx_se0, tx_dat, busy, byte_ready}), 0);
  endtask

  task automatic t_token_fs();
    do_packet(4'h9, 1'b0, 1'b0, 0, -1, 1'b0, "R2 R4 R5");
  endtask

  task automatic t_handshake_ls();
    do_packet(4'h2, 1'b1, 1'b0, 0, -1, 1'b0, "R4 R6 low speed");
  endtask

  task automatic t_data_crc_fs();
    pay_bytes[0] = 8'h01; pay_bytes[1] = 8'hFF; pay_bytes[2] = 8'hFF; pay_bytes[3] = 8'h3C;
    do_packet(4'h3, 1'b0, 1'b1, 4, -1, 1'b0, "R3 R7 R8");
  endtask

  task automatic t_data_ls_glitch();
    pay_bytes[0] = 8'hA5; pay_bytes[1] = 8'h7E;
    do_packet(4'hB, 1'b1, 1'b1, 2, -1, 1'b1, "R12 start while busy, R8");
  endtask

  task automatic t_zero_len_crc();
    do_packet(4'h3, 1'b0, 1'b1, 0, -1, 1'b0, "R8 zero length");
  endtask

  task automatic t_ones_before_eop();
    pay_bytes[0] = 8'hFC;
    do_packet(4'h3, 1'b0, 1'b0, 1, -1, 1'b0, "R3 no stuff before EOP");
  endtask

  task automatic t_underrun();
    pay_bytes[0] = 8'h12; pay_bytes[1] = 8'h34; pay_bytes[2] = 8'h56;
    do_packet(4'hC, 1'b0, 1'b1, 3, 1, 1'b0, "R9 underrun");
  endtask

  task automatic t_keepalive();
    run_cmd(2'd1, 4'h0, 1'b1, 1'b0, 0, -1, 1'b0);
    exp_n = 3; exp_sym[0] = 2; exp_sym[1] = 2; exp_sym[2] = 1;
    check_frame(FS_CLKS * LS_MULT, 1'b1, "R10 keep-alive");
  endtask

  task automatic t_bus_reset();
    run_cmd(2'd2, 4'h0, 1'b1, 1'b0, 0, -1, 1'b0);
    exp_n = RESET_BITS;
    for (int i = 0; i < RESET_BITS; i++) exp_sym[i] = 2;
    check_frame(FS_CLKS, 1'b1, "R11 R13 bus reset");
  endtask

  task automatic t_rx_lockout();
    int seen;
    seen = 0;
    rx_busy = 1'b1;
    @(negedge clk);
    cmd = 2'd0; pid = 4'h5; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    repeat (60) begin
      @(negedge clk);
      if (tx_en || busy) seen++;
    end
    check(seen == 0, "R12", "activity while rx_busy", seen, 0);
    rx_busy = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_token_fs();
    t_handshake_ls();
    t_data_crc_fs();
    t_data_ls_glitch();
    t_zero_len_crc();
    t_ones_before_eop();
    t_underrun();
    t_keepalive();
    t_bus_reset();
    t_rx_lockout();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule